// File: doc/BRIEF.md
# Serial Magnitude Comparator (LSB First)

This block decides the ordering of two unsigned numbers that arrive one bit pair per clock, least significant pair first. Each cycle it takes one bit of operand A and the bit of equal weight from operand B. It then reports whether the pairs seen so far in the current word make A greater than B, less than B, or equal to B.

Bits arrive from the low end of the word. So a later pair always carries more weight than every earlier one. A later pair that differs therefore overrides any earlier verdict, and a later pair that matches leaves the verdict unchanged.

A start strobe comes with the first pair of each word and discards the history of the previous word. The block does not count bits, so a word may have any length. The surrounding logic decides when the last pair has gone in and reads the verdict on the following cycle.

Top module: `serialMagCompare`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to the equal verdict. After that edge, `aGreater` and `aLess` both read 0.
- R2: A pair with `aBit`=1 and `bBit`=0 sets `aGreater`=1 and `aLess`=0 one cycle later, whatever the earlier verdict was and whatever `startWord` is.
- R3: A pair with `aBit`=0 and `bBit`=1 sets `aLess`=1 and `aGreater`=0 one cycle later, whatever the earlier verdict was and whatever `startWord` is.
- R4: A pair with equal bits and `startWord`=0 leaves `aGreater` and `aLess` unchanged in the next cycle.
- R5: A pair with equal bits and `startWord`=1 gives `aGreater`=0 and `aLess`=0 one cycle later. The pair is judged as if the history were equal.
- R6: `aGreater` and `aLess` are never both 1.
- R7: For any word length, one cycle after the most significant pair has been applied, the outputs read as follows: 10 when A>B, 01 when A<B, and 00 when A=B. These values are written as {aGreater,aLess}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| startWord | input | 1 | High together with the least significant pair of a new word |
| aBit | input | 1 | Current serial bit of operand A |
| bBit | input | 1 | Current serial bit of operand B |
| aGreater | output | 1 | 1 when the pairs so far make A > B |
| aLess | output | 1 | 1 when the pairs so far make A < B |

## Verification
Each verdict comes from a registered state, so the effect of a pair driven before a rising edge shows up just after that edge. It is due one cycle after the pair, and no later. The bench drives each pair at a falling edge and samples the outputs 1 ns after the next rising edge. It compares them there with a state model advanced by that same pair. The word-level verdict of R7 is checked at that same sample point after the last pair, against a plain unsigned comparison of the two assembled operands.

// File: rtl/cmpSerialPkg.sv
package cmpSerialPkg;

  // Verdict held between pairs
  typedef enum logic [1:0] {
    ST_EQ  = 2'b00,
    ST_AHI = 2'b01,
    ST_ALO = 2'b10
  } cmpState_e;

  // Strobes from the datapath to the control
  typedef struct packed {
    logic restart;
    logic aWins;
    logic bWins;
  } pairStrobe_t;

endpackage

// File: rtl/cmpPairSlice.sv
module cmpPairSlice
  import cmpSerialPkg::*;
(
  input  logic        startWord,
  input  logic        aBit,
  input  logic        bBit,
  input  cmpState_e   curState,
  output pairStrobe_t strobe,
  output logic        aGreater,
  output logic        aLess
);

  // Classify the incoming pair
  always_comb begin
    strobe.restart = startWord;
    strobe.aWins   = aBit & ~bBit;
    strobe.bWins   = ~aBit & bBit;
  end

  // Decode the registered verdict
  assign aGreater = (curState == ST_AHI);
  assign aLess    = (curState == ST_ALO);

endmodule

// File: rtl/cmpSeqCtl.sv
module cmpSeqCtl
  import cmpSerialPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  pairStrobe_t strobe,
  output cmpState_e   curState
);

  cmpState_e baseState;
  cmpState_e nextState;

  always_comb begin
    baseState = strobe.restart ? ST_EQ : curState;
    if (strobe.aWins)      nextState = ST_AHI;
    else if (strobe.bWins) nextState = ST_ALO;
    else                   nextState = baseState;
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_EQ;
    else     curState <= nextState;
  end

  // R1: reset leaves the equal verdict
  p_reset_eq_r1: assert property (@(posedge clk) rst |=> (curState == ST_EQ))
    else $error("reset did not return to equal verdict");

  // R6: state stays inside the three legal codes
  p_legal_state_r6: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_EQ) || (curState == ST_AHI) || (curState == ST_ALO))
    else $error("illegal verdict code");

endmodule

// File: rtl/serialMagCompare.sv
module serialMagCompare
  import cmpSerialPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic startWord,
  input  logic aBit,
  input  logic bBit,
  output logic aGreater,
  output logic aLess
);

  pairStrobe_t strobe;
  cmpState_e   curState;

  cmpPairSlice i_slice (
    .startWord (startWord),
    .aBit      (aBit),
    .bBit      (bBit),
    .curState  (curState),
    .strobe    (strobe),
    .aGreater  (aGreater),
    .aLess     (aLess)
  );

  cmpSeqCtl i_ctl (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curState (curState)
  );

  // R2: a 1/0 pair yields A greater next cycle
  p_a_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (aBit && !bBit) |=> (aGreater && !aLess))
    else $error("1/0 pair did not give A greater");

  // R3: a 0/1 pair yields A less next cycle
  p_b_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (!aBit && bBit) |=> (aLess && !aGreater))
    else $error("0/1 pair did not give A less");

  // R4: an equal pair inside a word holds the verdict
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!startWord && (aBit == bBit)) |=> $stable({aGreater, aLess}))
    else $error("equal pair changed the verdict");

  // R5: an equal pair with the start strobe gives equal
  p_start_eq_r5: assert property (@(posedge clk) disable iff (rst)
    (startWord && (aBit == bBit)) |=> (!aGreater && !aLess))
    else $error("start with equal pair did not clear history");

  // R6: outputs never both high
  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(aGreater && aLess))
    else $error("both verdict outputs high");

endmodule

// File: tb/test_serialMagCompare.sv
`timescale 1ns/1ps
module test_serialMagCompare;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startWord = 1'b0;
  logic aBit = 1'b0;
  logic bBit = 1'b0;
  logic aGreater, aLess;

  int nChecks = 0;
  int nFails  = 0;
  int modelSt = 0; // 0 equal, 1 A greater, 2 A less

  always #2 clk = ~clk;

  serialMagCompare i_serialMagCompare (
    .clk(clk), .rst(rst), .startWord(startWord),
    .aBit(aBit), .bBit(bBit), .aGreater(aGreater), .aLess(aLess)
  );

  function automatic int modelNext(int st, bit s, bit a, bit b);
    int base = s ? 0 : st;
    if (a && !b) return 1;
    if (!a && b) return 2;
    return base;
  endfunction

  function automatic logic [1:0] expOut(int st);
    if (st == 1) return 2'b10;
    if (st == 2) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(bit s, bit a, bit b, string req);
    @(negedge clk);
    startWord = s; aBit = a; bBit = b;
    @(posedge clk);
    #1;
    modelSt = modelNext(modelSt, s, a, b);
    check(req, {aGreater, aLess}, expOut(modelSt));
    check("R6", {1'b0, aGreater & aLess}, 2'b00);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; startWord = 1'($urandom); aBit = 1'($urandom); bBit = 1'($urandom);
    repeat (2) @(posedge clk);
    #1;
    modelSt = 0;
    check("R1", {aGreater, aLess}, 2'b00);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic word(logic [63:0] av, logic [63:0] bv, int n, string req);
    logic [63:0] am = av;
    logic [63:0] bm = bv;
    logic [1:0]  expW;
    for (int i = 0; i < n; i++)
      step(i == 0, av[i], bv[i], req);
    if (n < 64) begin
      am = av & ((64'd1 << n) - 64'd1);
      bm = bv & ((64'd1 << n) - 64'd1);
    end
    expW = (am > bm) ? 2'b10 : (am < bm) ? 2'b01 : 2'b00;
    check("R7 word verdict", {aGreater, aLess}, expW);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();                         // R1 reset state

    // R2 then R4: greater, then equal pairs hold
    step(1, 1, 0, "R2 start with 1/0");
    step(0, 1, 1, "R4 hold after 1/1");
    step(0, 0, 0, "R4 hold after 0/0");
    // R3 overrides an earlier greater verdict
    step(0, 0, 1, "R3 override to less");
    step(0, 0, 0, "R4 hold less");
    step(0, 1, 0, "R2 override to greater");
    // R5: equal pair with start clears history
    step(1, 1, 1, "R5 start clears");
    step(0, 0, 1, "R3 less");
    step(1, 0, 0, "R5 start clears less");
    step(1, 0, 1, "R3 start with 0/1");

    // R7 directed words: MSB overrides, equal, length 1 and 60
    word(64'b01, 64'b10, 2, "R7 msb override");
    word(64'hABCDE, 64'hABCDE, 20, "R7 equal");
    word(64'd1, 64'd0, 1, "R7 length one");
    word(64'h0800_0000_0000_0001, 64'h0000_0000_0000_0002, 60, "R7 length sixty");

    // R1 mid-run reset after greater
    step(1, 1, 0, "R2 before reset");
    doReset();

    // Random words with biased equal bits
    for (int w = 0; w < 300; w++) begin
      logic [63:0] av = {$urandom, $urandom};
      logic [63:0] bv = av ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      int n = 1 + int'($urandom % 48);
      word(av, bv, n, "R7 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule